// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache with Per-Word Stores

The block is a write-back data cache with direct mapping. Each line holds a double word made of two 32-bit words. Each word carries its own even-parity bit. Each line also has a tag, a valid flag and a dirty flag. The tag store is a separate memory with its own read address. The address of an incoming request goes to the tag store at once. The tag is compared in the next cycle, and the data store is read or written only after that comparison.

Loads always return the whole double word. A store names one or both words through a two-bit enable, and a word that is not enabled keeps its contents without being read first. When a miss evicts a modified line, the old double word goes out on a write-back port and the line is then refilled on a fill port. A parity fault on an unmodified line is repaired by dropping the line and fetching it again. A fault on a modified line cannot be repaired, so it raises a sticky machine-check output.

Top module: `dcache_top`

## Requirements
- R1: The low INDEX_W bits of the double-word address `req_addr_i` select the line and the remaining bits form the tag. Two addresses with the same index and different tags displace each other.
- R2: A load returns the full double word on `rsp_rdata_o`, with word 0 in bits [31:0] and word 1 in bits [63:32].
- R3: A store writes only the words whose bit in `req_wen_i` is 1 (bit 0 selects word 0, bit 1 selects word 1). The other word keeps its previous value.
- R4: The tag is compared in the cycle after the request is accepted. A store hit responds 1 cycle after the accepting clock edge. A load hit responds 2 cycles after it, because the data read follows the tag check.
- R5: A store hit marks the line dirty. The parity of each written word is recomputed from that word's new data only, which clears any earlier parity fault in that word.
- R6: A miss on a dirty line first raises `wb_req_o` with the old tag and index and the old double word. These are held until `wb_ack_i`, and only then is a fill requested. A miss on a clean or invalid line issues only the fill.
- R7: Parity is even, one bit per word, and the fill port supplies it (`fill_par_i[w]` for word w). A parity fault on a clean line invalidates the line and fetches it again, and the load then returns correct data.
- R8: A parity fault found by a load on a dirty line raises `mchk_o`, and that load gets no response.
- R9: Once `mchk_o` is high it stays high until reset, and `req_ready_o` stays low.
- R10: Reset clears every valid and dirty flag and `mchk_o`. The first access after reset misses without any write-back.
- R11: `fill_req_o` and `fill_addr_o` (the requested tag and index) stay stable until `fill_ack_i`. The returned double word is then installed as a clean line and the access is retried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted at this edge when valid |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_wen_i | input | 2 | Per-word store enables |
| req_addr_i | input | ADDR_W | Double-word address |
| req_wdata_i | input | 64 | Store data |
| rsp_valid_o | output | 1 | Access complete |
| rsp_rdata_o | output | 64 | Load data |
| wb_req_o | output | 1 | Write-back request |
| wb_addr_o | output | ADDR_W | Write-back double-word address |
| wb_data_o | output | 64 | Write-back data |
| wb_ack_i | input | 1 | Write-back accepted |
| fill_req_o | output | 1 | Fill request |
| fill_addr_o | output | ADDR_W | Fill double-word address |
| fill_data_i | input | 64 | Fill data |
| fill_par_i | input | 2 | Per-word parity from memory |
| fill_ack_i | input | 1 | Fill data valid |
| mchk_o | output | 1 | Fatal machine check, sticky |

## Verification
The bench builds the cache with ADDR_W = 6 and INDEX_W = 2, which gives four lines and a 16-entry tag space. Conflicting addresses are then only four apart, so evictions of clean lines, evictions of dirty lines and retries after a fill all come up within a few dozen accesses. The memory model on the bench side can flip the parity of one word in a single fill delivery. This lets a clean-line fault, a fault that a later store overwrites, and a fatal dirty-line fault each be produced on purpose on the fourth line.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TAG,
    ST_DATA,
    ST_WB,
    ST_FILL,
    ST_RETRY
  } dc_state_e;
endpackage

// File: rtl/dc_tag_ram.sv
module dc_tag_ram #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 10
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [TAG_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [TAG_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] mem_q [DEPTH];
  logic [TAG_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rd_q <= mem_q[raddr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/dc_data_ram.sv
module dc_data_ram #(
  parameter int IDX_W  = 6,
  parameter int WORD_W = 32,
  parameter int NWORDS = 2
) (
  input  logic                     clk_i,
  input  logic [IDX_W-1:0]         addr_i,
  input  logic [NWORDS-1:0]        we_i,
  input  logic [NWORDS*WORD_W-1:0] wdata_i,
  input  logic [NWORDS-1:0]        wpar_i,
  output logic [NWORDS*WORD_W-1:0] rdata_o,
  output logic [NWORDS-1:0]        rpar_o
);
  localparam int DEPTH = 1 << IDX_W;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic              par_q [DEPTH];
    logic [WORD_W-1:0] rd_q;
    logic              rp_q;

    // independent write strobe per word: no read-modify-write
    always_ff @(posedge clk_i) begin
      if (we_i[w]) begin
        mem_q[addr_i] <= wdata_i[w*WORD_W +: WORD_W];
        par_q[addr_i] <= wpar_i[w];
      end
      rd_q <= mem_q[addr_i];
      rp_q <= par_q[addr_i];
    end

    assign rdata_o[w*WORD_W +: WORD_W] = rd_q;
    assign rpar_o[w]                   = rp_q;
  end
endmodule

// File: rtl/dcache_top.sv
module dcache_top
  import dcache_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int INDEX_W = 6,
  parameter int WORD_W  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_we_i,
  input  logic [1:0]          req_wen_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [2*WORD_W-1:0] req_wdata_i,
  output logic                rsp_valid_o,
  output logic [2*WORD_W-1:0] rsp_rdata_o,
  output logic                wb_req_o,
  output logic [ADDR_W-1:0]   wb_addr_o,
  output logic [2*WORD_W-1:0] wb_data_o,
  input  logic                wb_ack_i,
  output logic                fill_req_o,
  output logic [ADDR_W-1:0]   fill_addr_o,
  input  logic [2*WORD_W-1:0] fill_data_i,
  input  logic [1:0]          fill_par_i,
  input  logic                fill_ack_i,
  output logic                mchk_o
);
  localparam int NWORDS = 2;
  localparam int LINE_W = NWORDS * WORD_W;
  localparam int TAG_W  = ADDR_W - INDEX_W;
  localparam int LINES  = 1 << INDEX_W;

  dc_state_e state_q, state_d;

  logic [INDEX_W-1:0] idx_q;
  logic [TAG_W-1:0]   tag_q;
  logic               we_q;
  logic [NWORDS-1:0]  wen_q;
  logic [LINE_W-1:0]  wdata_q;
  logic [LINES-1:0]   valid_q, dirty_q;
  logic               mchk_q;

  logic [INDEX_W-1:0] tag_raddr;
  logic [TAG_W-1:0]   tag_rd;
  logic               tag_we;
  logic [LINE_W-1:0]  data_rd, data_wdata;
  logic [NWORDS-1:0]  par_rd, par_calc, store_par, data_wpar, data_we;

  logic accept, hit, line_valid, line_dirty, perr;
  logic set_dirty, fill_done, clr_valid, raise_mchk;

  assign req_ready_o = (state_q == ST_IDLE) && !mchk_q;
  assign accept      = req_valid_i && req_ready_o;

  // tag store is addressed straight from the request while idle
  assign tag_raddr = (state_q == ST_IDLE) ? req_addr_i[INDEX_W-1:0] : idx_q;

  dc_tag_ram #(.IDX_W(INDEX_W), .TAG_W(TAG_W)) u_tag (
    .clk_i   (clk_i),
    .we_i    (tag_we),
    .waddr_i (idx_q),
    .wdata_i (tag_q),
    .raddr_i (tag_raddr),
    .rdata_o (tag_rd)
  );

  dc_data_ram #(.IDX_W(INDEX_W), .WORD_W(WORD_W), .NWORDS(NWORDS)) u_data (
    .clk_i   (clk_i),
    .addr_i  (idx_q),
    .we_i    (data_we),
    .wdata_i (data_wdata),
    .wpar_i  (data_wpar),
    .rdata_o (data_rd),
    .rpar_o  (par_rd)
  );

  for (genvar w = 0; w < NWORDS; w++) begin : g_par
    assign par_calc[w]  = ^data_rd[w*WORD_W +: WORD_W];
    assign store_par[w] = ^wdata_q[w*WORD_W +: WORD_W];
  end

  assign line_valid = valid_q[idx_q];
  assign line_dirty = dirty_q[idx_q];
  assign hit        = line_valid && (tag_rd == tag_q);
  assign perr       = |(par_calc ^ par_rd);

  always_comb begin
    state_d     = state_q;
    data_we     = '0;
    data_wdata  = wdata_q;
    data_wpar   = store_par;
    tag_we      = 1'b0;
    set_dirty   = 1'b0;
    fill_done   = 1'b0;
    clr_valid   = 1'b0;
    raise_mchk  = 1'b0;
    rsp_valid_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_TAG;
      ST_TAG: begin
        if (hit && we_q) begin
          data_we     = wen_q;
          set_dirty   = 1'b1;
          rsp_valid_o = 1'b1;
          state_d     = ST_IDLE;
        end else begin
          state_d = ST_DATA;
        end
      end
      ST_DATA: begin
        if (hit && !we_q) begin
          if (!perr) begin
            rsp_valid_o = 1'b1;
            state_d     = ST_IDLE;
          end else if (line_dirty) begin
            raise_mchk = 1'b1;
            state_d    = ST_IDLE;
          end else begin
            clr_valid = 1'b1;
            state_d   = ST_FILL;
          end
        end else if (line_valid && line_dirty) begin
          state_d = ST_WB;
        end else begin
          state_d = ST_FILL;
        end
      end
      ST_WB: if (wb_ack_i) state_d = ST_FILL;
      ST_FILL: begin
        if (fill_ack_i) begin
          data_we    = '1;
          data_wdata = fill_data_i;
          data_wpar  = fill_par_i;
          tag_we     = 1'b1;
          fill_done  = 1'b1;
          state_d    = ST_RETRY;
        end
      end
      ST_RETRY: state_d = ST_TAG;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      tag_q   <= '0;
      we_q    <= 1'b0;
      wen_q   <= '0;
      wdata_q <= '0;
      valid_q <= '0;
      dirty_q <= '0;
      mchk_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        idx_q   <= req_addr_i[INDEX_W-1:0];
        tag_q   <= req_addr_i[ADDR_W-1:INDEX_W];
        we_q    <= req_we_i;
        wen_q   <= req_wen_i;
        wdata_q <= req_wdata_i;
      end
      if (set_dirty) dirty_q[idx_q] <= 1'b1;
      if (clr_valid) valid_q[idx_q] <= 1'b0;
      if (fill_done) begin
        valid_q[idx_q] <= 1'b1;
        dirty_q[idx_q] <= 1'b0;
      end
      if (raise_mchk) mchk_q <= 1'b1;
    end
  end

  assign rsp_rdata_o = data_rd;
  assign wb_req_o    = (state_q == ST_WB);
  assign wb_addr_o   = {tag_rd, idx_q};
  assign wb_data_o   = data_rd;
  assign fill_req_o  = (state_q == ST_FILL);
  assign fill_addr_o = {tag_q, idx_q};
  assign mchk_o      = mchk_q;

  AST_WB_THEN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o && wb_ack_i |=> fill_req_o); // R6
  AST_WB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o && !wb_ack_i |=> wb_req_o && $stable(wb_addr_o) && $stable(wb_data_o)); // R6
  AST_FILL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o && !fill_ack_i |=> fill_req_o && $stable(fill_addr_o)); // R11
  AST_MCHK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mchk_o |=> mchk_o); // R9
  AST_MCHK_NO_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mchk_o |=> !rsp_valid_o); // R8
endmodule

// File: tb/tb_dcache_top.sv
`timescale 1ns/1ps
module tb_dcache_top;
  localparam int AW = 6;
  localparam int IW = 2;
  localparam int NA = 1 << AW;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        req_valid_i = 0, req_we_i = 0;
  logic [1:0]  req_wen_i = 0;
  logic [AW-1:0] req_addr_i = 0;
  logic [63:0] req_wdata_i = 0;
  logic        req_ready_o, rsp_valid_o, wb_req_o, fill_req_o, mchk_o;
  logic [63:0] rsp_rdata_o, wb_data_o;
  logic [AW-1:0] wb_addr_o, fill_addr_o;
  logic        wb_ack_i = 0, fill_ack_i = 0;
  logic [63:0] fill_data_i = 0;
  logic [1:0]  fill_par_i = 0;

  always #4 clk_i = ~clk_i;

  dcache_top #(.ADDR_W(AW), .INDEX_W(IW), .WORD_W(32)) dut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_we_i, .req_wen_i,
    .req_addr_i, .req_wdata_i, .rsp_valid_o, .rsp_rdata_o, .wb_req_o,
    .wb_addr_o, .wb_data_o, .wb_ack_i, .fill_req_o, .fill_addr_o,
    .fill_data_i, .fill_par_i, .fill_ack_i, .mchk_o
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  wen;
    logic [5:0]  addr;
    logic [63:0] wdata;
    logic [1:0]  fills;
    logic [1:0]  wbs;
    logic [1:0]  lat;   // 0 = not checked
  } vec_t;

  localparam vec_t TBL [13] = '{
    '{1'b0, 2'b00, 6'h00, 64'h0, 2'd1, 2'd0, 2'd0},
    '{1'b0, 2'b00, 6'h00, 64'h0, 2'd0, 2'd0, 2'd2},
    '{1'b1, 2'b01, 6'h00, 64'hFFFF_0000_AAAA_0001, 2'd0, 2'd0, 2'd1},
    '{1'b0, 2'b00, 6'h04, 64'h0, 2'd1, 2'd1, 2'd0},
    '{1'b0, 2'b00, 6'h00, 64'h0, 2'd1, 2'd0, 2'd0},
    '{1'b1, 2'b11, 6'h01, 64'h1111_2222_3333_4444, 2'd1, 2'd0, 2'd0},
    '{1'b1, 2'b10, 6'h01, 64'h5555_6666_7777_8888, 2'd0, 2'd0, 2'd1},
    '{1'b0, 2'b00, 6'h11, 64'h0, 2'd1, 2'd1, 2'd0},
    '{1'b0, 2'b00, 6'h01, 64'h0, 2'd1, 2'd0, 2'd0},
    '{1'b0, 2'b00, 6'h02, 64'h0, 2'd1, 2'd0, 2'd0},
    '{1'b1, 2'b10, 6'h06, 64'hDEAD_BEEF_0BAD_F00D, 2'd1, 2'd0, 2'd0},
    '{1'b0, 2'b00, 6'h06, 64'h0, 2'd0, 2'd0, 2'd2},
    '{1'b0, 2'b00, 6'h02, 64'h0, 2'd1, 2'd1, 2'd0}
  };

  logic [63:0] mem  [NA];
  logic [63:0] gold [NA];
  logic [1:0]  bad  [NA];

  int n_tests = 0, n_fail = 0;
  logic [63:0] got_rd;
  int got_fills, got_wbs, got_lat;
  logic got_rsp, got_mchk;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h exp %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 0; req_valid_i = 0; fill_ack_i = 0; wb_ack_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic serve();
    if (fill_req_o && !fill_ack_i) begin
      fill_data_i = mem[fill_addr_o];
      fill_par_i  = {^mem[fill_addr_o][63:32], ^mem[fill_addr_o][31:0]} ^ bad[fill_addr_o];
      bad[fill_addr_o] = 2'b00;
      fill_ack_i = 1;
      got_fills++;
    end else fill_ack_i = 0;
    if (wb_req_o && !wb_ack_i) begin
      mem[wb_addr_o] = wb_data_o;
      wb_ack_i = 1;
      got_wbs++;
    end else wb_ack_i = 0;
  endtask

  task automatic do_op(input logic we, input logic [1:0] wen,
                       input logic [AW-1:0] a, input logic [63:0] wd);
    got_fills = 0; got_wbs = 0; got_rsp = 0; got_mchk = 0; got_rd = '0;
    @(negedge clk_i);
    req_valid_i = 1; req_we_i = we; req_wen_i = wen;
    req_addr_i = a; req_wdata_i = wd;
    while (!req_ready_o && !mchk_o) @(negedge clk_i);
    if (mchk_o) begin
      req_valid_i = 0; got_mchk = 1; return;
    end
    if (we) begin
      if (wen[0]) gold[a][31:0]  = wd[31:0];
      if (wen[1]) gold[a][63:32] = wd[63:32];
    end
    @(negedge clk_i);
    req_valid_i = 0;
    got_lat = 1;
    while (got_lat < 300) begin
      if (rsp_valid_o) begin got_rsp = 1; got_rd = rsp_rdata_o; break; end
      if (mchk_o) begin got_mchk = 1; break; end
      serve();
      @(negedge clk_i);
      got_lat++;
    end
    if (got_lat >= 300) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: op at %h hung, got %0d exp <300", a, got_lat);
    end
    fill_ack_i = 0; wb_ack_i = 0;
  endtask

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: global timeout, got 1 exp 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NA; i++) begin
      mem[i]  = {32'h1000_0000 + i, 32'h2000_0000 + i};
      gold[i] = mem[i];
      bad[i]  = 2'b00;
    end
    do_reset();
    // R10 reset state
    check("R10", "ready after reset", req_ready_o, 1);
    check("R10", "mchk after reset", mchk_o, 0);
    check("R10", "no bus req after reset", {wb_req_o, fill_req_o, rsp_valid_o}, 0);

    // table: R1 conflicts, R2 data, R3 word stores, R4 latency, R6 evictions
    foreach (TBL[i]) begin
      do_op(TBL[i].we, TBL[i].wen, TBL[i].addr, TBL[i].wdata);
      check("R6", $sformatf("row %0d fills", i), got_fills, TBL[i].fills);
      check("R6", $sformatf("row %0d writebacks", i), got_wbs, TBL[i].wbs);
      check("R1", $sformatf("row %0d response", i), got_rsp, 1);
      if (!TBL[i].we)
        check("R2", $sformatf("row %0d load data", i), got_rd, gold[TBL[i].addr]);
      if (TBL[i].lat != 0)
        check("R4", $sformatf("row %0d latency", i), got_lat, TBL[i].lat);
    end
    check("R3", "untouched word kept on partial store", gold[6'h01][31:0], 32'h3333_4444);
    do_op(0, 2'b00, 6'h01, 0);
    check("R3", "partial store result", got_rd, 64'h5555_6666_3333_4444);

    // R7 clean-line parity fault: refetch
    bad[6'h03] = 2'b01;
    do_op(0, 2'b00, 6'h03, 0);
    check("R7", "clean fault fills", got_fills, 2);
    check("R7", "clean fault data", got_rd, gold[6'h03]);
    check("R7", "clean fault no mchk", mchk_o, 0);

    // R5 store recomputes parity of written word
    bad[6'h07] = 2'b10;
    do_op(1, 2'b10, 6'h07, 64'hCAFE_F00D_0000_0000);
    do_op(0, 2'b00, 6'h07, 0);
    check("R5", "recomputed parity no refetch", got_fills, 0);
    check("R5", "recomputed parity data", got_rd, gold[6'h07]);
    check("R5", "recomputed parity no mchk", mchk_o, 0);

    // R8 dirty-line fault
    bad[6'h0B] = 2'b10;
    do_op(1, 2'b01, 6'h0B, 64'h0000_0000_ABCD_1234);
    check("R6", "dirty evict wrote back", mem[6'h07], gold[6'h07]);
    do_op(0, 2'b00, 6'h0B, 0);
    check("R8", "dirty fault mchk", got_mchk, 1);
    check("R8", "dirty fault no response", got_rsp, 0);

    // R9 sticky
    repeat (5) @(negedge clk_i);
    check("R9", "mchk held", mchk_o, 1);
    check("R9", "ready low", req_ready_o, 0);

    // R10 reset clears valid/dirty and mchk
    do_reset();
    check("R10", "mchk cleared", mchk_o, 0);
    do_op(0, 2'b00, 6'h0B, 0);
    check("R10", "post-reset fills", got_fills, 1);
    check("R10", "post-reset no writeback", got_wbs, 0);
    check("R11", "post-reset fill data", got_rd, mem[6'h0B]);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule